// File: doc/BRIEF.md
# Dual-Width Flag Integer ALU

This block is a 64-bit integer arithmetic and logic unit that produces two sets of condition flags from one operation. One set describes the result as seen by 32-bit code, taken from the low word. The other describes the full 64-bit result. Each set holds negative, zero, overflow and carry. The second operand is either the `b_i` register value or a 13-bit immediate, sign-extended. A flag-enable input decides whether an operation writes the stored flags. The stored carry of the 32-bit set feeds the add-with-carry and subtract-with-carry forms.

Tagged add and tagged subtract treat the two low bits of each operand as a type tag. A nonzero tag forces the 32-bit overflow flag. The trapping tagged forms raise `trap_o` when that tagged overflow occurs. In that case the stored flags are left untouched.

The unit accepts one operation per clock when `valid_i` is high. The result, `valid_o` and `trap_o` come out of registers one edge later. The flag outputs show the stored flag registers. Both flag outputs use the same nibble layout: bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.

Top module: `alu_dualcc`

## Requirements
- R1: During and after reset, `valid_o` and `trap_o` are low, `result_o` is zero and both flag nibbles are zero. The nibble layout is N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: An operation presented with `valid_i` high at a clock edge appears on `result_o` with `valid_o` high right after that edge. `valid_o` is low after an edge at which `valid_i` was low.
- R3: When `imm_sel_i` is 1, the second operand is `imm_i` sign-extended from bit 12 to 64 bits and `b_i` has no effect.
- R4: Op code 0 computes a+b. Op code 1 computes a+b+c, where c is the stored 32-bit C flag. Carry is the carry out of bit 31 for the 32-bit set and out of bit 63 for the 64-bit set.
- R5: Op code 2 computes a-b. Op code 3 computes a-b-c, with c as in R4. C reports an unsigned borrow per width: it is set when the low-word (or full) value of a is below that of b plus the borrow-in.
- R6: Addition overflow is set when both operands share a sign and the result sign differs from it. Subtraction overflow is set when the operand signs differ and the result sign differs from that of a. These use bit 31 for the 32-bit set and bit 63 for the 64-bit set.
- R7: N is result bit 31 or 63. Z is set when the low 32 bits, or all 64 bits, of the result are zero.
- R8: Op codes 4 to 9 compute AND, AND-NOT, OR, OR-NOT, XOR and XNOR. The NOT forms invert b. When flags are written, V and C are cleared in both sets.
- R9: Op codes 10 (tagged add) and 11 (tagged subtract) act like codes 0 and 2. In addition, the 32-bit V is set when either operand has a nonzero value in bits 1:0. The 64-bit V follows R6 only.
- R10: Op codes 12 and 13 act like 10 and 11. They raise `trap_o` with the result when the 32-bit tagged V would be set. A trapping operation leaves both flag sets unchanged, and no other op code raises `trap_o`.
- R11: When `set_flags_i` is low, the operation still produces its result and both flag sets keep their values.
- R12: Op codes 14 and 15 produce a zero result, leave the flags unchanged and never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand register value |
| imm_i | input | 13 | Signed immediate |
| imm_sel_i | input | 1 | Use the immediate as the second operand |
| set_flags_i | input | 1 | Write the flag registers |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |
| trap_o | output | 1 | Tag overflow exception |
| flags32_o | output | 4 | Stored low-word flags {N,Z,V,C} |
| flags64_o | output | 4 | Stored full-width flags {N,Z,V,C} |

## Verification
The bound checker watches several properties on every cycle:
- the one-edge latency of `valid_o`;
- that the flags hold whenever no flag write is requested, when a trap fires, and for unknown op codes;
- that only the trapping tagged codes can trap;
- that logical operations clear V and C and copy both sign bits into N;
- that a full-width zero always implies a low-word zero.

The bench scenarios cover the rest: the numeric results, carry and borrow at each width, overflow at bit 31 versus bit 63, immediate sign extension, carry chaining through the stored 32-bit C, and tag-bit overflow. These need operand values chosen to hit each boundary, so they are checked by a scoreboard model rather than by an invariant.

// File: rtl/alu_dualcc_pkg.sv
package alu_dualcc_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_AND   = 4'd4,
    OP_ANDN  = 4'd5,
    OP_OR    = 4'd6,
    OP_ORN   = 4'd7,
    OP_XOR   = 4'd8,
    OP_XNOR  = 4'd9,
    OP_TADD  = 4'd10,
    OP_TSUB  = 4'd11,
    OP_TADDT = 4'd12,
    OP_TSUBT = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  output logic [DATA_W-1:0] b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  assign b_o = imm_sel_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : b_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_lo_o,
  output logic              c_hi_o
);
  localparam int HI_W = DATA_W - LOW_W;

  logic [DATA_W-1:0] bx;
  logic [LOW_W:0]    lo;
  logic [HI_W:0]     hi;

  // subtract as a + ~b + cin; carry out is raw (no-borrow for subtract)
  assign bx = sub_i ? ~b_i : b_i;
  assign lo = {1'b0, a_i[LOW_W-1:0]} + {1'b0, bx[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};
  assign hi = {1'b0, a_i[DATA_W-1:LOW_W]} + {1'b0, bx[DATA_W-1:LOW_W]} + {{HI_W{1'b0}}, lo[LOW_W]};

  assign sum_o  = {hi[HI_W-1:0], lo[LOW_W-1:0]};
  assign c_lo_o = lo[LOW_W];
  assign c_hi_o = hi[HI_W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] bb;

  // fn[0] inverts b; fn[3] picks xor, else fn[1] picks or, else and
  assign bb = fn_i[0] ? ~b_i : b_i;

  always_comb begin
    if (fn_i[3])      res_o = a_i ^ bb;
    else if (fn_i[1]) res_o = a_i | bb;
    else              res_o = a_i & bb;
  end
endmodule

// File: rtl/alu_ccgen.sv
module alu_ccgen
  import alu_dualcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         sub_i,
  input  logic         logic_i,
  input  logic         cout_i,
  input  logic         tag_i,
  output cc_t          cc_o
);
  logic sign_ok;
  logic ovf;

  assign sign_ok = sub_i ? (a_msb_i != b_msb_i) : (a_msb_i == b_msb_i);
  assign ovf     = sign_ok && (res_i[W-1] != a_msb_i);

  assign cc_o.n = res_i[W-1];
  assign cc_o.z = (res_i == '0);
  assign cc_o.v = logic_i ? 1'b0 : (ovf | tag_i);
  assign cc_o.c = logic_i ? 1'b0 : (sub_i ? ~cout_i : cout_i);
endmodule

// File: rtl/alu_dualcc.sv
module alu_dualcc
  import alu_dualcc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32,
  parameter int IMM_W  = 13,
  parameter int TAG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  input  logic              set_flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              trap_o,
  output logic [3:0]        flags32_o,
  output logic [3:0]        flags64_o
);
  localparam int NGRP = 2;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum, logic_res, res;
  logic              c_lo, c_hi, add_cin;
  logic              is_sub, use_cin, is_logic, is_tag, is_trapping, op_known;
  logic              tag_err, trap_d, upd;
  cc_t               cc32_q, cc64_q;
  cc_t               cc_new [NGRP];

  alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .b_i      (b_i),
    .imm_i    (imm_i),
    .imm_sel_i(imm_sel_i),
    .b_o      (opnd_b)
  );

  always_comb begin
    is_sub      = 1'b0;
    use_cin     = 1'b0;
    is_logic    = 1'b0;
    is_tag      = 1'b0;
    is_trapping = 1'b0;
    op_known    = 1'b1;
    case (op_i)
      OP_ADD:  ;
      OP_ADDC: use_cin = 1'b1;
      OP_SUB:  is_sub = 1'b1;
      OP_SUBC: begin is_sub = 1'b1; use_cin = 1'b1; end
      OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_XOR, OP_XNOR: is_logic = 1'b1;
      OP_TADD:  is_tag = 1'b1;
      OP_TSUB:  begin is_tag = 1'b1; is_sub = 1'b1; end
      OP_TADDT: begin is_tag = 1'b1; is_trapping = 1'b1; end
      OP_TSUBT: begin is_tag = 1'b1; is_trapping = 1'b1; is_sub = 1'b1; end
      default:  op_known = 1'b0;
    endcase
  end

  // carry-in always comes from the stored low-word carry
  always_comb begin
    if (is_sub) add_cin = use_cin ? ~cc32_q.c : 1'b1;
    else        add_cin = use_cin ?  cc32_q.c : 1'b0;
  end

  alu_addsub #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .sub_i (is_sub),
    .cin_i (add_cin),
    .sum_o (sum),
    .c_lo_o(c_lo),
    .c_hi_o(c_hi)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (a_i),
    .b_i  (opnd_b),
    .fn_i (op_i),
    .res_o(logic_res)
  );

  always_comb begin
    if (!op_known)     res = '0;
    else if (is_logic) res = logic_res;
    else               res = sum;
  end

  assign tag_err = is_tag && ((|a_i[TAG_W-1:0]) || (|opnd_b[TAG_W-1:0]));

  for (genvar g = 0; g < NGRP; g++) begin : g_cc
    localparam int W = (g == 0) ? LOW_W : DATA_W;
    alu_ccgen #(.W(W)) u_cc (
      .res_i  (res[W-1:0]),
      .a_msb_i(a_i[W-1]),
      .b_msb_i(opnd_b[W-1]),
      .sub_i  (is_sub),
      .logic_i(is_logic),
      .cout_i ((g == 0) ? c_lo : c_hi),
      .tag_i  ((g == 0) ? tag_err : 1'b0),
      .cc_o   (cc_new[g])
    );
  end

  assign trap_d = valid_i && is_trapping && cc_new[0].v;
  assign upd    = valid_i && set_flags_i && op_known && !trap_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      trap_o   <= 1'b0;
      cc32_q   <= '0;
      cc64_q   <= '0;
    end else begin
      valid_o <= valid_i;
      trap_o  <= trap_d;
      if (valid_i) result_o <= res;
      if (upd) begin
        cc32_q <= cc_new[0];
        cc64_q <= cc_new[1];
      end
    end
  end

  assign flags32_o = cc32_q;
  assign flags64_o = cc64_q;
endmodule

// File: rtl/alu_dualcc_chk.sv
module alu_dualcc_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              set_flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              trap_o,
  input logic [3:0]        flags32_o,
  input logic [3:0]        flags64_o
);
  logic is_logic_op, is_trap_op, is_bad_op;
  assign is_logic_op = (op_i >= 4'd4) && (op_i <= 4'd9);
  assign is_trap_op  = (op_i == 4'd12) || (op_i == 4'd13);
  assign is_bad_op   = (op_i >= 4'd14);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!valid_o && !trap_o && flags32_o == 4'd0 && flags64_o == 4'd0);
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_zero_nest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags64_o[2] |-> flags32_o[2]);
  assert_logic_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && is_logic_op) |=>
      (flags32_o[1:0] == 2'b00 && flags64_o[1:0] == 2'b00 &&
       flags32_o[3] == result_o[31] && flags64_o[3] == result_o[DATA_W-1]));
  assert_trap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($stable(flags32_o) && $stable(flags64_o) && valid_o));
  assert_trap_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_trap_op) |=> !trap_o);
  assert_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && set_flags_i) |=> ($stable(flags32_o) && $stable(flags64_o)));
  assert_bad_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_bad_op) |=>
      (result_o == '0 && !trap_o && $stable(flags32_o) && $stable(flags64_o)));
endmodule

bind alu_dualcc alu_dualcc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .set_flags_i(set_flags_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .trap_o     (trap_o),
  .flags32_o  (flags32_o),
  .flags64_o  (flags64_o)
);

// File: tb/tb_alu_dualcc.sv
`timescale 1ns/1ps
module tb_alu_dualcc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [12:0] imm_i = '0;
  logic        imm_sel_i = 1'b0, set_flags_i = 1'b0;
  logic        valid_o, trap_o;
  logic [63:0] result_o;
  logic [3:0]  flags32_o, flags64_o;

  always #2 clk = ~clk;

  alu_dualcc dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i),
    .set_flags_i(set_flags_i), .valid_o(valid_o), .result_o(result_o),
    .trap_o(trap_o), .flags32_o(flags32_o), .flags64_o(flags64_o)
  );

  typedef struct {
    logic [63:0] res;
    logic        trap;
    logic [3:0]  f32;
    logic [3:0]  f64;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  logic [3:0] m32 = '0, m64 = '0;

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // reference model of one operation; updates the model flags
  task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [12:0] imm, input bit sel, input bit setf, input string tag);
    logic [63:0] b2, r;
    logic [64:0] s65;
    logic [32:0] s33;
    logic c32, c64, v32, v64, ci, trap, known, lg;
    exp_t e;
    b2 = sel ? {{51{imm[12]}}, imm} : b;
    ci = m32[0];
    c32 = 0; c64 = 0; v32 = 0; v64 = 0; trap = 0; known = 1; lg = 0; r = '0;
    case (op)
      4'd0, 4'd1, 4'd10, 4'd12: begin
        logic cin;
        cin = (op == 4'd1) ? ci : 1'b0;
        s65 = {1'b0, a} + {1'b0, b2} + {64'd0, cin};
        s33 = {1'b0, a[31:0]} + {1'b0, b2[31:0]} + {32'd0, cin};
        r = s65[63:0]; c64 = s65[64]; c32 = s33[32];
        v64 = (a[63] == b2[63]) && (r[63] != a[63]);
        v32 = (a[31] == b2[31]) && (r[31] != a[31]);
      end
      4'd2, 4'd3, 4'd11, 4'd13: begin
        logic bw;
        bw = (op == 4'd3) ? ci : 1'b0;
        r = a - b2 - {63'd0, bw};
        c64 = ({1'b0, a} < ({1'b0, b2} + {64'd0, bw}));
        c32 = ({1'b0, a[31:0]} < ({1'b0, b2[31:0]} + {32'd0, bw}));
        v64 = (a[63] != b2[63]) && (r[63] != a[63]);
        v32 = (a[31] != b2[31]) && (r[31] != a[31]);
      end
      4'd4: begin r = a & b2;    lg = 1; end
      4'd5: begin r = a & ~b2;   lg = 1; end
      4'd6: begin r = a | b2;    lg = 1; end
      4'd7: begin r = a | ~b2;   lg = 1; end
      4'd8: begin r = a ^ b2;    lg = 1; end
      4'd9: begin r = ~(a ^ b2); lg = 1; end
      default: known = 0;
    endcase
    if (op >= 4'd10 && op <= 4'd13) v32 = v32 | (a[1:0] != 0) | (b2[1:0] != 0);
    trap = (op == 4'd12 || op == 4'd13) && v32;
    if (setf && known && !trap) begin
      m32 = {r[31], r[31:0] == 0, v32, c32};
      m64 = {r[63], r == 0, v64, c64};
    end
    e.res = r; e.trap = trap; e.f32 = m32; e.f64 = m64; e.tag = tag;
    q.push_back(e);
    op_i = op; a_i = a; b_i = b; imm_i = imm; imm_sel_i = sel; set_flags_i = setf;
    valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    repeat (n) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R2", $sformatf("idle valid_o act=%0b exp=0", valid_o));
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "valid_o with no pending item act=1 exp=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result_o == e.res && trap_o == e.trap && flags32_o == e.f32 && flags64_o == e.f64,
              e.tag, $sformatf("act res=%h trap=%0b f32=%h f64=%h exp res=%h trap=%0b f32=%h f64=%h",
                result_o, trap_o, flags32_o, flags64_o, e.res, e.trap, e.f32, e.f64));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 0 && trap_o == 0 && result_o == 0 && flags32_o == 0 && flags64_o == 0, "R1",
          $sformatf("reset act v=%0b t=%0b r=%h f=%h/%h exp all zero",
                    valid_o, trap_o, result_o, flags32_o, flags64_o));
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R7 basic add, back-to-back stream (R2)
    issue(4'd0, 64'd5, 64'd7, 13'd0, 0, 1, "R4_add");
    issue(4'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 13'd0, 0, 1, "R6_add_v32");
    issue(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 13'd0, 0, 1, "R7_add_zero_carry");
    issue(4'd1, 64'd10, 64'd20, 13'd0, 0, 1, "R4_addc_cin1");
    issue(4'd1, 64'd10, 64'd20, 13'd0, 0, 1, "R4_addc_cin0");
    idle(2);
    // R5 subtract and borrow
    issue(4'd2, 64'd3, 64'd5, 13'd0, 0, 1, "R5_sub_borrow");
    issue(4'd3, 64'd100, 64'd1, 13'd0, 0, 1, "R5_subc_bw1");
    issue(4'd2, 64'h1_0000_0000, 64'd1, 13'd0, 0, 1, "R5_sub_low_borrow");
    issue(4'd3, 64'd7, 64'd7, 13'd0, 0, 1, "R5_subc_bw_low");
    issue(4'd2, 64'h8000_0000_0000_0000, 64'd1, 13'd0, 0, 1, "R6_sub_v64");
    issue(4'd2, 64'h0000_0000_8000_0000, 64'd1, 13'd0, 0, 1, "R6_sub_v32");
    issue(4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 13'd0, 0, 1, "R6_add_v64");
    // R3 immediate
    issue(4'd0, 64'd10, 64'hDEAD_BEEF, 13'h1FFD, 1, 1, "R3_imm_neg");
    issue(4'd6, 64'd0, 64'hFFFF, 13'h0FFF, 1, 1, "R3_imm_pos");
    // R8 logic clears V/C after an op that set them
    issue(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_8000_0000, 13'd0, 0, 1, "R6_setup");
    issue(4'd4, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_0000_0F0F, 13'd0, 0, 1, "R8_and");
    issue(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 13'd0, 0, 1, "R8_andn");
    issue(4'd7, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 13'd0, 0, 1, "R8_orn");
    issue(4'd8, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 13'd0, 0, 1, "R8_xor_zero");
    issue(4'd9, 64'h0, 64'h0000_0000_FFFF_FFFF, 13'd0, 0, 1, "R8_xnor");
    // R11 no flag write
    issue(4'd2, 64'd0, 64'd1, 13'd0, 0, 0, "R11_noset");
    // R9 tagged arithmetic
    issue(4'd10, 64'd4, 64'd8, 13'd0, 0, 1, "R9_tadd_clean");
    issue(4'd10, 64'd5, 64'd8, 13'd0, 0, 1, "R9_tadd_tag_a");
    issue(4'd11, 64'd16, 64'd2, 13'd0, 0, 1, "R9_tsub_tag_b");
    issue(4'd11, 64'h0000_0000_8000_0000, 64'd4, 13'd0, 0, 1, "R9_tsub_ovf");
    // R10 trapping forms
    issue(4'd0, 64'd1, 64'd1, 13'd0, 0, 1, "R10_setup");
    issue(4'd12, 64'd3, 64'd4, 13'd0, 0, 1, "R10_taddt_trap");
    issue(4'd13, 64'd12, 64'd4, 13'd0, 0, 1, "R10_tsubt_clean");
    issue(4'd13, 64'h0000_0000_8000_0000, 64'd4, 13'd0, 0, 1, "R10_tsubt_ovf_trap");
    // R12 unknown codes
    issue(4'd14, 64'd9, 64'd9, 13'd0, 0, 1, "R12_op14");
    issue(4'd15, 64'hFFFF, 64'd1, 13'd0, 0, 1, "R12_op15");
    idle(3);
    check(q.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", q.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule